// File: doc/BRIEF.md
# Bit-Serial Two's Complement Negator

This block negates a two's complement number that arrives one bit per clock, least significant bit first. It works by a scan rule rather than an inverter and an adder. Every bit up to and including the lowest 1 leaves the block unchanged, and every bit above that 1 leaves it inverted. The only state is a single phase flag that records whether that first 1 has already gone past.

Words have no fixed length. A `start` strobe that comes with the lowest bit of a word begins the next word, and the flag is cleared for that bit. A cycle with `in_valid` low is a hole in the stream: it moves no state and produces no valid output. Each result bit is registered and comes out exactly one clock after the bit that produced it. Callers use the block to negate operands that travel on serial datapaths, with no parallel adder needed.

Top module: `tcs_serial_negate`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `out_valid` and `out_bit` to 0 and returns the phase flag to its cleared state. A bit accepted after reset without `start` is handled as the first bit of a word.
- R2: `out_valid` in each cycle equals `in_valid` of the previous cycle: one clock of latency, with no bits added or dropped.
- R3: While no 1 has yet been accepted in the current word, each accepted 0 appears unchanged on `out_bit` one clock later.
- R4: The first accepted 1 of a word appears unchanged on `out_bit` one clock later.
- R5: Every accepted bit that follows the first 1 of the same word appears inverted on `out_bit` one clock later.
- R6: A bit accepted together with `start` is handled as if no 1 had been seen, whatever the previous word left behind.
- R7: Cycles with `in_valid` low do not change the phase flag, so a word may contain holes of any length.
- R8: A word made only of 0 bits produces only 0 bits.
- R9: For any word of W bits, the output bits, gathered LSB first, equal (2^W − value) mod 2^W. For example, the 8-bit input 1001_0100 gives 0110_1100.
- R10: `out_bit` is 0 in every cycle in which `out_valid` is 0.
- R11: `start` has effect only in a cycle in which `in_valid` is high. A `start` strobe during a hole leaves the phase flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Marks the accepted bit as the lowest bit of a new word |
| in_valid | input | 1 | High when `in_bit` carries a bit of the stream |
| in_bit | input | 1 | Serial operand bit, LSB first |
| out_valid | output | 1 | High when `out_bit` carries a result bit |
| out_bit | output | 1 | Serial negated bit, one clock after its input |

## Verification
The block has no parameters, so the bench builds it in its only form. Because word length comes from the `start` strobe and not from a constant, the bench drives words of 1, 3, 8, 16 and 32 bits through the same instance. This covers a lone sign bit, words whose only 1 is the top bit, and words whose first 1 is the very first bit. The bench places holes and stray `start` strobes inside words, and it ends words with the flag set, so it exercises the clearing of the flag and the way it is held across holes.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   // Scan phase of the current word.
   typedef enum logic {
      PH_SEEK   = 1'b0,   // no 1 accepted yet: bits pass through
      PH_INVERT = 1'b1    // first 1 already passed: bits are flipped
   } tcs_phase_e;

endpackage

// File: rtl/tcs_phase_tracker.sv
module tcs_phase_tracker
   import tcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic       in_valid,
   input  logic       in_bit,
   output tcs_phase_e phase,
   output logic       flip_now
);

   tcs_phase_e phase_q;
   tcs_phase_e phase_base;

   // A start strobe accepted with a bit clears the phase for that very bit.
   always_comb begin
      phase_base = (in_valid && start) ? PH_SEEK : phase_q;
      flip_now   = (phase_base == PH_INVERT);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_SEEK;
      end else if (in_valid) begin
         if (in_bit || (phase_base == PH_INVERT))
            phase_q <= PH_INVERT;
         else
            phase_q <= PH_SEEK;
      end
   end

   assign phase = phase_q;

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(phase_q)); // R7

   AST_ONE_ARMS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_bit) |=> (phase_q == PH_INVERT)); // R4

   AST_START_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && start && !in_bit) |=> (phase_q == PH_SEEK)); // R6

endmodule

// File: rtl/tcs_bit_stage.sv
module tcs_bit_stage (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic in_bit,
   input  logic flip,
   output logic out_valid,
   output logic out_bit
);

   logic valid_q;
   logic bit_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         bit_q   <= 1'b0;
      end else begin
         valid_q <= in_valid;
         bit_q   <= in_valid & (in_bit ^ flip);
      end
   end

   assign out_valid = valid_q;
   assign out_bit   = bit_q;

   AST_VALID_ECHO_HI: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R2

   AST_VALID_ECHO_LO: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R2

   AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> !out_bit); // R10

endmodule

// File: rtl/tcs_serial_negate.sv
module tcs_serial_negate
   import tcs_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic in_valid,
   input  logic in_bit,
   output logic out_valid,
   output logic out_bit
);

   tcs_phase_e phase;
   logic       flip_now;

   tcs_phase_tracker u_track (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .in_valid (in_valid),
      .in_bit   (in_bit),
      .phase    (phase),
      .flip_now (flip_now)
   );

   tcs_bit_stage u_stage (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_bit    (in_bit),
      .flip      (flip_now),
      .out_valid (out_valid),
      .out_bit   (out_bit)
   );

   AST_SEEK_PASS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (phase == PH_SEEK)) |=> (out_bit == $past(in_bit))); // R3

   AST_START_PASS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && start) |=> (out_bit == $past(in_bit))); // R6

   AST_AFTER_ONE_FLIP: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !start && (phase == PH_INVERT)) |=> (out_bit != $past(in_bit))); // R5

   AST_STRAY_START: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && start) |=> $stable(phase)); // R11

endmodule

// File: tb/sim_tcs_serial_negate.sv
module sim_tcs_serial_negate;

   logic clk = 1'b0;
   logic rst, start, in_valid, in_bit;
   logic out_valid, out_bit;
   int   n_chk  = 0;
   int   n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   tcs_serial_negate u0 (
      .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
      .in_bit(in_bit), .out_valid(out_valid), .out_bit(out_bit)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // One idle cycle; optionally with a stray start. Checks the quiet output.
   task automatic hole(input logic stray);
      @(negedge clk);
      in_valid = 1'b0; in_bit = 1'b1; start = stray;
      @(posedge clk); #1;
      check("R2 hole valid", out_valid, 1'b0);
      check("R10 hole bit", out_bit, 1'b0);
   endtask

   // Send a word LSB first; holes after bits flagged in gaps, stray starts in strays.
   task automatic send_word(input logic [31:0] data, input int width,
                            input logic [31:0] gaps, input logic [31:0] strays,
                            input logic use_start, input string req);
      logic [31:0] mask, exp;
      mask = (width == 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
      exp  = (32'd0 - data) & mask;
      for (int i = 0; i < width; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_bit = data[i]; start = use_start && (i == 0);
         @(posedge clk); #1;
         check({req, " R2 valid"}, out_valid, 1'b1);
         check({req, " R9 bit"}, out_bit, exp[i]);
         if (gaps[i]) begin hole(strays[i]); hole(1'b0); end
      end
      @(negedge clk);
      in_valid = 1'b0; start = 1'b0;
   endtask

   task automatic t_reset;
      rst = 1'b1; start = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
      repeat (3) @(posedge clk); #1;
      check("R1 reset valid", out_valid, 1'b0);
      check("R1 reset bit", out_bit, 1'b0);
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic t_example;   // R9 R3 R4 R5
      send_word(32'h94, 8, 32'h0, 32'h0, 1'b1, "R9 example 10010100");
   endtask

   task automatic t_zero;      // R8
      send_word(32'h0, 16, 32'h0, 32'h0, 1'b1, "R8 zero word");
   endtask

   task automatic t_restart;   // R6: previous word ends flipped, next begins with 1
      send_word(32'h1, 4, 32'h0, 32'h0, 1'b1, "R6 first");
      send_word(32'h5, 3, 32'h0, 32'h0, 1'b1, "R6 restart one");
      send_word(32'h6, 3, 32'h0, 32'h0, 1'b1, "R6 restart zero");
   endtask

   task automatic t_holes;     // R7 R10 R11
      send_word(32'h0000_0110, 12, 32'h0000_0231, 32'h0000_0210, 1'b1, "R7 R11 holes");
   endtask

   task automatic t_widths;    // R3 R4 R5 R9
      send_word(32'h1, 1, 32'h0, 32'h0, 1'b1, "R4 one bit");
      send_word(32'h4, 3, 32'h0, 32'h0, 1'b1, "R3 top one");
      send_word(32'h8000_0000, 32, 32'h0, 32'h0, 1'b1, "R3 min32");
      send_word(32'hDEAD_BEEF, 32, 32'h0, 32'h0, 1'b1, "R5 w32");
      send_word(32'h0000_7FFF, 16, 32'h0, 32'h0, 1'b1, "R5 w16");
   endtask

   task automatic t_reset_midword;   // R1: reset clears the flag
      @(negedge clk); in_valid = 1'b1; in_bit = 1'b1; start = 1'b1;
      @(negedge clk); in_valid = 1'b0; start = 1'b0; rst = 1'b1;
      @(posedge clk); #1;
      check("R1 midword valid", out_valid, 1'b0);
      @(negedge clk); rst = 1'b0;
      send_word(32'h2, 4, 32'h0, 32'h0, 1'b0, "R1 after reset no start");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_example();
      t_zero();
      t_restart();
      t_holes();
      t_widths();
      t_reset_midword();
      repeat (2) @(posedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule